// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary scan data register for a device with a configurable number of bidirectional pads and input-only pads. Each bidirectional pad owns three scan cells: input, output and output enable. Each input-only pad owns a single input cell. Three further cells control scan logic and belong to no pad. Two of them sit at the serial-out end of the chain and set the enable and data of the scan output driver. The third sits at the serial-in end and serves as an update flag. Configuration pins have no cells at all.

An external test access port controller drives three strobes into the block: capture, shift and update. The block samples pad and core values in parallel. It moves them serially from `tdi` towards `tdo` and loads the update latches. While the external-test instruction is active, those latches drive the pads. At all other times the pads follow the core.

Top module: `bsr_chain`

## Requirements
- R1: The chain holds 3*N_BIDIR + N_INONLY + 3 cells. Bidirectional pad k has its input cell at position 2+3k, its output cell at 3+3k and its enable cell at 4+3k. Input-only pad j sits at position 3*N_BIDIR+2+j. Position 0 is nearest `tdo`.
- R2: Position 0 is the scan-output enable control, position 1 the scan-output data and the last position the update flag. Their update latches drive `tdo_ctl_oe`, `tdo_ctl_dat` and `upd_flag`. On capture each of these cells reloads its own latched value.
- R3: On a rising `tck` with `capture_dr` high, every cell loads at once. Input cells take `pad_di` or `in_pad`. Output and enable cells take the values now on `pad_do` and `pad_oe`. Capture wins over shift.
- R4: On a rising `tck` with `shift_dr` high and `capture_dr` low, the stage moves one place towards position 0 and `tdi` enters the last position. After a full-length shift, the bit sent in shift i sits at position i.
- R5: On a falling `tck` with `shift_dr` high, `tdo` loads position 0 of the shift stage. It holds at all other times.
- R6: On a falling `tck` with `update_dr` high, the update latches copy the shift stage. Otherwise they keep their value.
- R7: With `extest` high, `pad_do` and `pad_oe` come from the output and enable update latches. With `extest` low they equal `core_do` and `core_oe`, whatever the latches hold.
- R8: A low `rst_n` (test logic reset) asynchronously clears the shift stage, the update latches and `tdo`. All pad enables and the three control outputs then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low test logic reset, asynchronous |
| tdi | input | 1 | Serial scan input |
| capture_dr | input | 1 | Capture strobe from controller |
| shift_dr | input | 1 | Shift strobe from controller |
| update_dr | input | 1 | Update strobe from controller |
| extest | input | 1 | External-test instruction decode |
| core_do | input | N_BIDIR | Core output data per pad |
| core_oe | input | N_BIDIR | Core output enable per pad |
| pad_di | input | N_BIDIR | Value received on each bidirectional pad |
| in_pad | input | N_INONLY | Value on each input-only pad |
| pad_do | output | N_BIDIR | Data driven to each pad |
| pad_oe | output | N_BIDIR | Enable driven to each pad |
| tdo | output | 1 | Serial scan output |
| tdo_ctl_oe | output | 1 | Latched scan-output enable control |
| tdo_ctl_dat | output | 1 | Latched scan-output data control |
| upd_flag | output | 1 | Latched update flag |

## Verification
Inputs change one time unit after a rising `tck`. A capture or shift therefore lands on the next rising edge. An update lands on the falling edge halfway there, so the pads are checked after that edge.

A serial bit is due on `tdo` in the same cycle that shifts it. It appears at the falling edge before the shifting rising edge. The monitor samples two time units after each falling edge that sees `shift_dr` high, and pops one expected bit per sample. The driver queues each frame's bits in position order before its first shift cycle.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic [1:0] {
      CELL_IN  = 2'd0,
      CELL_OUT = 2'd1,
      CELL_OE  = 2'd2,
      CELL_CTL = 2'd3
   } cell_kind_e;

   localparam int CTL_OE_POS  = 0;
   localparam int CTL_DAT_POS = 1;
   localparam int PAD_BASE    = 2;

   function automatic int chain_len(input int nb, input int ni);
      return 3 * nb + ni + 3;
   endfunction

   function automatic int bidir_pos(input int k, input int slot);
      return PAD_BASE + 3 * k + slot;
   endfunction

   function automatic int inonly_pos(input int nb, input int j);
      return PAD_BASE + 3 * nb + j;
   endfunction

   function automatic cell_kind_e kind_of(input int nb, input int ni, input int pos);
      if (pos == CTL_OE_POS || pos == CTL_DAT_POS || pos == chain_len(nb, ni) - 1)
         return CELL_CTL;
      if (pos >= inonly_pos(nb, 0))
         return CELL_IN;
      case ((pos - PAD_BASE) % 3)
         0:       return CELL_IN;
         1:       return CELL_OUT;
         default: return CELL_OE;
      endcase
   endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
   parameter bit HAS_UPD = 1'b1
) (
   input  logic tck,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shf_en,
   input  logic upd_en,
   input  logic cap_val,
   input  logic ser_in,
   output logic q,
   output logic upd_q
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (cap_en) q <= cap_val;
      else if (shf_en) q <= ser_in;
   end

   // R3
   cell_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
      cap_en |=> (q == $past(cap_val)));

   // R4
   cell_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (shf_en && !cap_en) |=> (q == $past(ser_in)));

   if (HAS_UPD) begin : g_upd
      always_ff @(negedge tck or negedge rst_n) begin
         if (!rst_n)      upd_q <= 1'b0;
         else if (upd_en) upd_q <= q;
      end

      // R6
      latch_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
         !upd_en |=> $stable(upd_q));

      // R8
      latch_reset_chk: assert property (@(negedge tck)
         !rst_n |-> (upd_q == 1'b0));
   end else begin : g_no_upd
      logic unused_upd_en;
      assign unused_upd_en = upd_en;
      assign upd_q         = 1'b0;
   end

endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux #(
   parameter int WIDTH = 4
) (
   input  logic             extest,
   input  logic [WIDTH-1:0] core_do,
   input  logic [WIDTH-1:0] core_oe,
   input  logic [WIDTH-1:0] lat_do,
   input  logic [WIDTH-1:0] lat_oe,
   output logic [WIDTH-1:0] pad_do,
   output logic [WIDTH-1:0] pad_oe
);

   for (genvar k = 0; k < WIDTH; k++) begin : g_pad
      always_comb begin
         if (extest) begin
            pad_do[k] = lat_do[k];
            pad_oe[k] = lat_oe[k];
         end else begin
            pad_do[k] = core_do[k];
            pad_oe[k] = core_oe[k];
         end
      end
   end

endmodule

// File: rtl/bsr_tdo_stage.sv
module bsr_tdo_stage (
   input  logic tck,
   input  logic rst_n,
   input  logic shift_dr,
   input  logic head_bit,
   output logic tdo
);

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)        tdo <= 1'b0;
      else if (shift_dr) tdo <= head_bit;
   end

   // R5
   tdo_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
      !shift_dr |=> $stable(tdo));

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
   import bsr_pkg::*;
#(
   parameter int N_BIDIR  = 4,
   parameter int N_INONLY = 2
) (
   input  logic                tck,
   input  logic                rst_n,
   input  logic                tdi,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic                extest,
   input  logic [N_BIDIR-1:0]  core_do,
   input  logic [N_BIDIR-1:0]  core_oe,
   input  logic [N_BIDIR-1:0]  pad_di,
   input  logic [N_INONLY-1:0] in_pad,
   output logic [N_BIDIR-1:0]  pad_do,
   output logic [N_BIDIR-1:0]  pad_oe,
   output logic                tdo,
   output logic                tdo_ctl_oe,
   output logic                tdo_ctl_dat,
   output logic                upd_flag
);

   localparam int CHAIN_LEN = chain_len(N_BIDIR, N_INONLY);
   localparam int LAST_POS  = CHAIN_LEN - 1;
   localparam int IN_BASE   = inonly_pos(N_BIDIR, 0);

   if (N_BIDIR < 1) begin : g_bad_bidir
      $error("bsr_chain: N_BIDIR must be at least 1");
   end
   if (N_INONLY < 1) begin : g_bad_inonly
      $error("bsr_chain: N_INONLY must be at least 1");
   end

   logic [CHAIN_LEN-1:0] cap_vec;
   logic [CHAIN_LEN-1:0] ser_vec;
   logic [CHAIN_LEN-1:0] stage_q;
   logic [CHAIN_LEN-1:0] latch_q;
   logic [N_BIDIR-1:0]   lat_do;
   logic [N_BIDIR-1:0]   lat_oe;
   logic                 unused_latch_bits;

   assign ser_vec           = {tdi, stage_q[CHAIN_LEN-1:1]};
   assign unused_latch_bits = ^latch_q;

   for (genvar p = 0; p < CHAIN_LEN; p++) begin : g_cell
      localparam cell_kind_e KIND = kind_of(N_BIDIR, N_INONLY, p);

      if (KIND == CELL_CTL) begin : g_ctl
         assign cap_vec[p] = latch_q[p];
      end else if (KIND == CELL_IN && p >= IN_BASE) begin : g_inonly
         assign cap_vec[p] = in_pad[p-IN_BASE];
      end else if (KIND == CELL_IN) begin : g_bin
         assign cap_vec[p] = pad_di[(p-PAD_BASE)/3];
      end else if (KIND == CELL_OUT) begin : g_bout
         assign cap_vec[p] = pad_do[(p-PAD_BASE)/3];
      end else begin : g_boe
         assign cap_vec[p] = pad_oe[(p-PAD_BASE)/3];
      end

      bsr_cell #(
         .HAS_UPD (KIND != CELL_IN)
      ) u_cell (
         .tck     (tck),
         .rst_n   (rst_n),
         .cap_en  (capture_dr),
         .shf_en  (shift_dr),
         .upd_en  (update_dr),
         .cap_val (cap_vec[p]),
         .ser_in  (ser_vec[p]),
         .q       (stage_q[p]),
         .upd_q   (latch_q[p])
      );
   end

   for (genvar k = 0; k < N_BIDIR; k++) begin : g_lat_pick
      assign lat_do[k] = latch_q[bidir_pos(k, 1)];
      assign lat_oe[k] = latch_q[bidir_pos(k, 2)];
   end

   bsr_pad_mux #(
      .WIDTH (N_BIDIR)
   ) u_pad_mux (
      .extest  (extest),
      .core_do (core_do),
      .core_oe (core_oe),
      .lat_do  (lat_do),
      .lat_oe  (lat_oe),
      .pad_do  (pad_do),
      .pad_oe  (pad_oe)
   );

   bsr_tdo_stage u_tdo (
      .tck      (tck),
      .rst_n    (rst_n),
      .shift_dr (shift_dr),
      .head_bit (stage_q[0]),
      .tdo      (tdo)
   );

   assign tdo_ctl_oe  = latch_q[CTL_OE_POS];
   assign tdo_ctl_dat = latch_q[CTL_DAT_POS];
   assign upd_flag    = latch_q[LAST_POS];

endmodule

// File: tb/bsr_chain_bench.sv
module bsr_chain_bench;

   localparam int NB = 3;
   localparam int NI = 2;
   localparam int L  = 3 * NB + NI + 3;

   logic          tck = 1'b0;
   logic          rst_n = 1'b0;
   logic          tdi = 1'b0;
   logic          capture_dr = 1'b0;
   logic          shift_dr = 1'b0;
   logic          update_dr = 1'b0;
   logic          extest = 1'b0;
   logic [NB-1:0] core_do = '0;
   logic [NB-1:0] core_oe = '0;
   logic [NB-1:0] pad_di = '0;
   logic [NI-1:0] in_pad = '0;
   logic [NB-1:0] pad_do;
   logic [NB-1:0] pad_oe;
   logic          tdo;
   logic          tdo_ctl_oe;
   logic          tdo_ctl_dat;
   logic          upd_flag;

   int            n_chk = 0;
   int            n_fail = 0;
   bit            exp_q[$];
   logic [L-1:0]  m_sr  = '0;
   logic [L-1:0]  m_lat = '0;

   always #5 tck = ~tck;

   bsr_chain #(
      .N_BIDIR  (NB),
      .N_INONLY (NI)
   ) u_bsr_chain (
      .tck         (tck),
      .rst_n       (rst_n),
      .tdi         (tdi),
      .capture_dr  (capture_dr),
      .shift_dr    (shift_dr),
      .update_dr   (update_dr),
      .extest      (extest),
      .core_do     (core_do),
      .core_oe     (core_oe),
      .pad_di      (pad_di),
      .in_pad      (in_pad),
      .pad_do      (pad_do),
      .pad_oe      (pad_oe),
      .tdo         (tdo),
      .tdo_ctl_oe  (tdo_ctl_oe),
      .tdo_ctl_dat (tdo_ctl_dat),
      .upd_flag    (upd_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic step();
      @(posedge tck);
      #1;
   endtask

   function automatic logic [NB-1:0] exp_do();
      logic [NB-1:0] v;
      for (int k = 0; k < NB; k++) v[k] = extest ? m_lat[3 + 3 * k] : core_do[k];
      return v;
   endfunction

   function automatic logic [NB-1:0] exp_oe();
      logic [NB-1:0] v;
      for (int k = 0; k < NB; k++) v[k] = extest ? m_lat[4 + 3 * k] : core_oe[k];
      return v;
   endfunction

   // R1 position layout, R2 control cells reload their latches, R3 pad sources
   function automatic logic [L-1:0] cap_exp();
      logic [L-1:0]  v;
      logic [NB-1:0] d;
      logic [NB-1:0] e;
      d = exp_do();
      e = exp_oe();
      v = '0;
      v[0]   = m_lat[0];
      v[1]   = m_lat[1];
      v[L-1] = m_lat[L-1];
      for (int k = 0; k < NB; k++) begin
         v[2 + 3 * k] = pad_di[k];
         v[3 + 3 * k] = d[k];
         v[4 + 3 * k] = e[k];
      end
      for (int j = 0; j < NI; j++) v[3 * NB + 2 + j] = in_pad[j];
      return v;
   endfunction

   task automatic do_capture();
      logic [L-1:0] c;
      c = cap_exp();
      capture_dr = 1'b1;
      step();
      capture_dr = 1'b0;
      m_sr = c;
   endtask

   // R4 / R5: bit i of the stage is due on tdo during shift cycle i
   task automatic shift_frame(input logic [L-1:0] din);
      for (int i = 0; i < L; i++) exp_q.push_back(m_sr[i]);
      for (int i = 0; i < L; i++) begin
         shift_dr = 1'b1;
         tdi      = din[i];
         step();
      end
      shift_dr = 1'b0;
      m_sr     = din;
   endtask

   task automatic do_update();
      update_dr = 1'b1;
      step();
      update_dr = 1'b0;
      m_lat = m_sr;
   endtask

   task automatic check_outputs(input string tag);
      chk({tag, " pad_do"}, 32'(pad_do), 32'(exp_do()));
      chk({tag, " pad_oe"}, 32'(pad_oe), 32'(exp_oe()));
      chk({"R2 ", tag, " tdo_ctl_oe"}, 32'(tdo_ctl_oe), 32'(m_lat[0]));
      chk({"R2 ", tag, " tdo_ctl_dat"}, 32'(tdo_ctl_dat), 32'(m_lat[1]));
      chk({"R2 ", tag, " upd_flag"}, 32'(upd_flag), 32'(m_lat[L-1]));
   endtask

   // scoreboard monitor: one expected tdo bit per shift cycle
   initial begin
      forever begin
         @(negedge tck);
         #2;
         if (shift_dr && rst_n) begin
            if (exp_q.size() == 0) begin
               chk("R5 unexpected shift", 32'd1, 32'd0);
            end else begin
               chk("R4 R5 tdo stream", 32'(tdo), 32'(exp_q.pop_front()));
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
   end

   initial begin
      logic         last_bit;
      logic [L-1:0] p1;
      logic [L-1:0] p2;
      logic [L-1:0] p3;
      p1 = 14'h2A5B;
      p2 = 14'h13C6;
      p3 = 14'h3E91;

      // R8 reset state with extest asserted
      extest  = 1'b1;
      core_oe = '1;
      core_do = '1;
      repeat (3) step();
      chk("R8 reset pad_oe", 32'(pad_oe), 32'd0);
      chk("R8 reset tdo", 32'(tdo), 32'd0);
      chk("R8 reset upd_flag", 32'(upd_flag), 32'd0);
      rst_n = 1'b1;
      step();

      // R7 functional mode follows the core
      extest  = 1'b0;
      core_do = 3'b101;
      core_oe = 3'b110;
      pad_di  = 3'b011;
      in_pad  = 2'b10;
      #1;
      check_outputs("R7 core path");
      step();

      // R3 capture, R4 shift in p1
      do_capture();
      shift_frame(p1);
      do_update();
      check_outputs("R7 latches ignored");
      extest = 1'b1;
      #1;
      check_outputs("R7 extest drive p1");
      step();

      // R6 shift without update leaves pads untouched; R4 old contents come out
      shift_frame(p2);
      check_outputs("R6 hold during shift");
      do_update();
      check_outputs("R6 update p2");

      // R3 capture in extest: out/oe cells see latched drive
      core_do = 3'b010;
      pad_di  = 3'b100;
      in_pad  = 2'b01;
      step();
      do_capture();
      last_bit = m_sr[L-1];
      shift_frame(p3);

      // R5 tdo holds while not shifting
      repeat (3) step();
      chk("R5 tdo hold", 32'(tdo), 32'(last_bit));

      // R3 capture wins over shift in the same cycle
      pad_di = 3'b001;
      #1;
      exp_q.push_back(m_sr[0]);
      begin
         logic [L-1:0] c;
         c          = cap_exp();
         capture_dr = 1'b1;
         shift_dr   = 1'b1;
         tdi        = 1'b1;
         step();
         capture_dr = 1'b0;
         shift_dr   = 1'b0;
         m_sr       = c;
      end
      shift_frame(p1 ^ p3);

      // R8 mid-run reset clears latches and disables pads
      rst_n = 1'b0;
      #2;
      m_lat = '0;
      m_sr  = '0;
      chk("R8 async pad_oe", 32'(pad_oe), 32'd0);
      chk("R8 async tdo", 32'(tdo), 32'd0);
      check_outputs("R8 after reset");
      step();
      rst_n = 1'b1;
      step();
      do_capture();
      shift_frame(p2 ^ p1);

      repeat (2) step();
      chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
      finish_run();
   end

endmodule